// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a serial-peripheral slave that configures the power-management controls of a small battery-powered system. A host sends 8-bit command bytes, most significant bit first, while chip select is low. Depending on the top bit, a byte either writes 5 data bits into one of four small control registers or loads a 7-bit DAC threshold code in a single byte. The stored values drive parallel control outputs: two driver enables, two regulator enables, run/coast, the charger and backup controls, the output-voltage code and the DAC code.

During every frame the slave also returns a status byte. It holds three comparator results and a low-battery flag, captured when chip select falls, followed by four zero bits. All pins are oversampled by a faster system clock through a synchronizer with edge detection. A write takes effect only if the frame carried exactly eight clock rising edges. Every register returns to its power-on value on the asynchronous reset and while the active-low reset-comparator input is low.

Top module: `spi_ctrl_regs`

## Requirements
- R1: A byte with bit 7 = 0 and bits 6:5 = 0 stores bits 4:0 as {drv2_en, drv1_en, reg3_en, reg2_en, run}, bit 4 first.
- R2: A byte with bit 7 = 0 and bits 6:5 = 1 stores bits 3:0 as {lb_backup, backup, chg_hi, chg_lo}; bit 4 is ignored.
- R3: A byte with bit 7 = 0 and bits 6:5 = 2 stores bits 4:0 as the output-voltage code.
- R4: A byte with bit 7 = 0 and bits 6:5 = 3 changes no output.
- R5: A byte with bit 7 = 1 stores bits 6:0 as the DAC code.
- R6: A frame commits only if exactly 8 rising edges of the serial clock occur while chip select is low; shorter or longer frames change no output.
- R7: After the asynchronous reset all control bits and the DAC code are 0 and the output-voltage code is 5'b01100.
- R8: While the reset-comparator input is low, all registers return to the values of R7.
- R9: The slave returns a status byte MSB first, updated on serial clock falling edges: bit 7 = ch2, bit 6 = ch1, bit 5 = ch0, bit 4 = low-battery, bits 3:0 = 0 (ch2..ch0 = ch_cmp_i[2:0]).
- R10: The status is captured when chip select falls; input changes during the frame are not returned.
- R11: sdo_oe_o is low while chip select is high. After chip select falls, sdo_o presents status bit 7 before the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (high impedance when low) |
| ch_cmp_i | input | 3 | Comparator results {ch2, ch1, ch0} |
| lowbat_i | input | 1 | Low-battery flag |
| rst_cmp_ni | input | 1 | Reset-comparator level, low restores power-on values |
| drv2_en_o | output | 1 | Driver 2 enable |
| drv1_en_o | output | 1 | Driver 1 enable |
| reg3_en_o | output | 1 | Regulator 3 enable |
| reg2_en_o | output | 1 | Regulator 2 enable |
| run_o | output | 1 | Run (1) or coast (0) |
| lb_backup_o | output | 1 | Low battery arms backup |
| backup_o | output | 1 | Backup regulator on |
| chg_hi_o | output | 1 | High-current charge |
| chg_lo_o | output | 1 | Low-current charge |
| vout_code_o | output | 5 | Output-voltage code |
| dac_code_o | output | 7 | DAC threshold code |

## Verification
The bench builds the block with its default parameters: a 3-stage synchronizer, 8-bit frames, a 4-bit status nibble and 7-bit DAC word. It drives the serial clock at one sixteenth of the system clock, which leaves room for the synchronizer latency on every edge. With these values, frames of 5 and 9 bits and a status change in the middle of a frame can all be produced, along with writes to each of the four addresses and the DAC path.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 5;
  localparam int CHG_W  = 4;
  localparam int DAC_W  = BYTE_W - 1;
  localparam int N_CH   = 3;
  localparam int STAT_W = N_CH + 1;

  localparam logic [DATA_W-1:0] POR_DRV  = '0;
  localparam logic [CHG_W-1:0]  POR_CHG  = '0;
  localparam logic [DATA_W-1:0] POR_VOUT = 5'b01100;
  localparam logic [DAC_W-1:0]  POR_DAC  = '0;

  typedef enum logic [1:0] {
    A_DRV   = 2'd0,
    A_CHG   = 2'd1,
    A_VOUT  = 2'd2,
    A_SPARE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 8,
  parameter int             STAGES  = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st[g] <= RST_VAL;
      else if (g == 0) st[g] <= d_i;
      else            st[g] <= st[(g > 0) ? g-1 : 0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= RST_VAL;
    else         prev_o <= st[STAGES-1];
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
  parameter int BYTE_W = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              cs_p_i,
  input  logic              sck_s_i,
  input  logic              sck_p_i,
  input  logic              sdi_s_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              load_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_MAX = BYTE_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PAD_W   = BYTE_W - STAT_W;

  logic              cs_fall, cs_rise, sck_rise, sck_fall;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              oe_q;

  assign cs_fall  = cs_p_i & ~cs_s_i;
  assign cs_rise  = ~cs_p_i & cs_s_i;
  assign sck_rise = ~sck_p_i & sck_s_i & ~cs_s_i;
  assign sck_fall = sck_p_i & ~sck_s_i & ~cs_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (cs_fall) begin
        cnt   <= '0;
        tx_sh <= {stat_i, {PAD_W{1'b0}}};
        oe_q  <= 1'b1;
      end else if (cs_rise) begin
        oe_q  <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh <= {rx_sh[BYTE_W-2:0], sdi_s_i};
          if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
        // shift only after the first sampled bit
        if (sck_fall && cnt != '0) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign load_o   = cs_fall;
  assign commit_o = cs_rise && (cnt == CNT_W'(BYTE_W));
  assign byte_o   = rx_sh;
  assign sdo_oe_o = oe_q;
  assign sdo_o    = oe_q & tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DATA_W-1:0] drv_o,
  output logic [CHG_W-1:0]  chg_o,
  output logic [DATA_W-1:0] vout_o,
  output logic [DAC_W-1:0]  dac_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(byte_i[BYTE_W-2 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_o  <= POR_DRV;
      chg_o  <= POR_CHG;
      vout_o <= POR_VOUT;
      dac_o  <= POR_DAC;
    end else if (por_i) begin
      drv_o  <= POR_DRV;
      chg_o  <= POR_CHG;
      vout_o <= POR_VOUT;
      dac_o  <= POR_DAC;
    end else if (commit_i) begin
      if (byte_i[BYTE_W-1]) begin
        dac_o <= byte_i[DAC_W-1:0];
      end else begin
        case (addr)
          A_DRV:   drv_o  <= byte_i[DATA_W-1:0];
          A_CHG:   chg_o  <= byte_i[CHG_W-1:0];
          A_VOUT:  vout_o <= byte_i[DATA_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            sck_i,
  input  logic            sdi_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  input  logic [N_CH-1:0] ch_cmp_i,
  input  logic            lowbat_i,
  input  logic            rst_cmp_ni,
  output logic            drv2_en_o,
  output logic            drv1_en_o,
  output logic            reg3_en_o,
  output logic            reg2_en_o,
  output logic            run_o,
  output logic            lb_backup_o,
  output logic            backup_o,
  output logic            chg_hi_o,
  output logic            chg_lo_o,
  output logic [DATA_W-1:0] vout_code_o,
  output logic [DAC_W-1:0]  dac_code_o
);
  localparam int SYNC_W = STAT_W + 4;
  // {rst_cmp, cs, sck, sdi, lowbat, ch}
  localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, {(SYNC_W-2){1'b0}}};

  logic [SYNC_W-1:0] raw, syn, syn_p;
  logic [STAT_W-1:0] stat_s;
  logic              por_req, load, commit;
  logic [BYTE_W-1:0] rx_byte;
  logic [DATA_W-1:0] drv;
  logic [CHG_W-1:0]  chg;

  assign raw = {rst_cmp_ni, cs_ni, sck_i, sdi_i, lowbat_i, ch_cmp_i};

  spi_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn), .prev_o(syn_p)
  );

  assign stat_s  = {syn[N_CH-1:0], syn[N_CH]};
  assign por_req = ~syn[SYNC_W-1];

  spi_frame #(.BYTE_W(BYTE_W), .STAT_W(STAT_W)) u_frame (
    .clk_i, .rst_ni,
    .cs_s_i(syn[SYNC_W-2]), .cs_p_i(syn_p[SYNC_W-2]),
    .sck_s_i(syn[SYNC_W-3]), .sck_p_i(syn_p[SYNC_W-3]),
    .sdi_s_i(syn[SYNC_W-4]), .stat_i(stat_s),
    .sdo_o, .sdo_oe_o, .load_o(load), .commit_o(commit), .byte_o(rx_byte)
  );

  spi_reg_bank u_bank (
    .clk_i, .rst_ni, .por_i(por_req), .commit_i(commit), .byte_i(rx_byte),
    .drv_o(drv), .chg_o(chg), .vout_o(vout_code_o), .dac_o(dac_code_o)
  );

  assign {drv2_en_o, drv1_en_o, reg3_en_o, reg2_en_o, run_o} = drv;
  assign {lb_backup_o, backup_o, chg_hi_o, chg_lo_o}         = chg;
endmodule

// File: rtl/spi_ctrl_regs_chk.sv
module spi_ctrl_regs_chk
  import spi_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load,
  input logic              commit,
  input logic              por_req,
  input logic [STAT_W-1:0] stat_s,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic [DATA_W-1:0] drv,
  input logic [CHG_W-1:0]  chg,
  input logic [DATA_W-1:0] vout_code_o,
  input logic [DAC_W-1:0]  dac_code_o
);
  // R11
  stat_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> sdo_oe_o && sdo_o == $past(stat_s[STAT_W-1]));

  // R5
  dac_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && rx_byte[BYTE_W-1] && !por_req |=> dac_code_o == $past(rx_byte[DAC_W-1:0]));

  // R3
  vout_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && rx_byte[BYTE_W-1:BYTE_W-3] == 3'b010 && !por_req
    |=> vout_code_o == $past(rx_byte[DATA_W-1:0]));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit && !por_req |=> $stable({drv, chg, vout_code_o, dac_code_o}));

  // R8
  por_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req |=> drv == '0 && chg == '0 && vout_code_o == 5'b01100 && dac_code_o == '0);
endmodule

bind spi_ctrl_regs spi_ctrl_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load(load), .commit(commit), .por_req(por_req),
  .stat_s(stat_s), .rx_byte(rx_byte), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .drv(drv), .chg(chg), .vout_code_o(vout_code_o), .dac_code_o(dac_code_o)
);

// File: tb/spi_ctrl_regs_bench.sv
module spi_ctrl_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [2:0] ch = 3'b0;
  logic lowbat = 1'b0, rst_cmp_n = 1'b1;
  logic sdo, sdo_oe;
  logic drv2, drv1, reg3, reg2, run, lbb, bkp, chh, chl;
  logic [4:0] vout;
  logic [6:0] dac;

  int checks = 0, errors = 0;
  logic [7:0] cap;
  logic [3:0] exp_q[$];

  always #10 clk = ~clk;

  spi_ctrl_regs u_spi_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ch_cmp_i(ch), .lowbat_i(lowbat),
    .rst_cmp_ni(rst_cmp_n), .drv2_en_o(drv2), .drv1_en_o(drv1),
    .reg3_en_o(reg3), .reg2_en_o(reg2), .run_o(run), .lb_backup_o(lbb),
    .backup_o(bkp), .chg_hi_o(chh), .chg_lo_o(chl),
    .vout_code_o(vout), .dac_code_o(dac)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_stat(input logic [3:0] s);
    ch = s[3:1];
    lowbat = s[0];
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one frame of nbits; optional status change after bit 2
  task automatic xfer(input logic [7:0] b, input int nbits, input logic [3:0] exp_stat,
                      input bit do_mid, input logic [3:0] mid_stat);
    cap = '0;
    if (nbits == 8) exp_q.push_back(exp_stat);
    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(8);
    // R11: MSB present before any clock edge
    chk("R11 oe", 32'(sdo_oe), 32'd1);
    chk("R11 msb", 32'(sdo), 32'(exp_stat[3]));
    for (int i = 0; i < nbits; i++) begin
      sdi = b[(7 - (i % 8))];
      wait_clk(8);
      sck = 1'b1;
      cap = {cap[6:0], sdo};
      wait_clk(8);
      sck = 1'b0;
      if (do_mid && i == 2) set_stat(mid_stat);
    end
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  // monitor: scoreboard compare of returned status byte
  always @(posedge cs_n) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      e = exp_q.pop_front();
      chk("R9 R10 status", 32'(cap), 32'({e, 4'b0000}));
    end
  end

  task automatic chk_regs(input string req, input logic [4:0] e_drv, input logic [3:0] e_chg,
                          input logic [4:0] e_vout, input logic [6:0] e_dac);
    chk({req, " drv"}, 32'({drv2, drv1, reg3, reg2, run}), 32'(e_drv));
    chk({req, " chg"}, 32'({lbb, bkp, chh, chl}), 32'(e_chg));
    chk({req, " vout"}, 32'(vout), 32'(e_vout));
    chk({req, " dac"}, 32'(dac), 32'(e_dac));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(5);
    // R7
    chk_regs("R7 reset", 5'b0, 4'b0, 5'b01100, 7'd0);
    rst_n = 1'b1;
    wait_clk(5);
    chk_regs("R7 after release", 5'b0, 4'b0, 5'b01100, 7'd0);
    chk("R11 idle oe", 32'(sdo_oe), 32'd0);

    set_stat(4'b1010);
    wait_clk(6);
    // R1
    xfer(8'b0_00_10101, 8, 4'b1010, 1'b0, 4'b0);
    chk_regs("R1", 5'b10101, 4'b0, 5'b01100, 7'd0);
    chk("R11 oe after frame", 32'(sdo_oe), 32'd0);

    set_stat(4'b0101);
    wait_clk(6);
    // R2: bit 4 ignored
    xfer(8'b0_01_11011, 8, 4'b0101, 1'b0, 4'b0);
    chk_regs("R2", 5'b10101, 4'b1011, 5'b01100, 7'd0);

    set_stat(4'b1111);
    wait_clk(6);
    // R3
    xfer(8'b0_10_11011, 8, 4'b1111, 1'b0, 4'b0);
    chk_regs("R3", 5'b10101, 4'b1011, 5'b11011, 7'd0);

    // R4
    xfer(8'b0_11_11111, 8, 4'b1111, 1'b0, 4'b0);
    chk_regs("R4", 5'b10101, 4'b1011, 5'b11011, 7'd0);

    // R5
    set_stat(4'b0000);
    wait_clk(6);
    xfer(8'b1_1010101, 8, 4'b0000, 1'b0, 4'b0);
    chk_regs("R5", 5'b10101, 4'b1011, 5'b11011, 7'h55);

    // R6: short and long frames discarded
    xfer(8'b0_00_00000, 5, 4'b0000, 1'b0, 4'b0);
    chk_regs("R6 short", 5'b10101, 4'b1011, 5'b11011, 7'h55);
    xfer(8'b1_0000011, 9, 4'b0000, 1'b0, 4'b0);
    chk_regs("R6 long", 5'b10101, 4'b1011, 5'b11011, 7'h55);

    // R10: status captured at chip-select fall
    set_stat(4'b1001);
    wait_clk(6);
    xfer(8'b1_0000001, 8, 4'b1001, 1'b1, 4'b0110);
    chk_regs("R5 second", 5'b10101, 4'b1011, 5'b11011, 7'h01);
    wait_clk(6);
    xfer(8'b0_11_00000, 8, 4'b0110, 1'b0, 4'b0);

    // R8
    rst_cmp_n = 1'b0;
    wait_clk(10);
    rst_cmp_n = 1'b1;
    wait_clk(10);
    chk_regs("R8", 5'b0, 4'b0, 5'b01100, 7'd0);

    xfer(8'b0_00_01010, 8, 4'b0110, 1'b0, 4'b0);
    chk_regs("R1 after R8", 5'b01010, 4'b0, 5'b01100, 7'd0);

    // R7: asynchronous reset mid-operation
    rst_n = 1'b0;
    #3;
    chk_regs("R7 async", 5'b0, 4'b0, 5'b01100, 7'd0);
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule